// File: doc/BRIEF.md
# Eight-Pin I/O Port with Per-Pin Peripheral Takeover

This block is a general-purpose I/O port of eight pins. Software sets a direction bit and an output bit per pin, plus one port-wide switch that disables all pull-ups. It does this through a small synchronous register interface. From the sampled pin levels it reads back a synchronized copy.

Next to the software view, each pin accepts takeover controls from a peripheral that shares the pin. The controls come as enable/value pairs for four things: the pull-up, the output driver enable, the driven level and the digital input enable. A peripheral can also ask for the stored output bit to flip on every cycle it holds a toggle request. Without a takeover, the input enable follows the power state: inputs are live while the system is awake and shut off while it sleeps.

The peripheral also receives each pin's gated input level straight from the pad, without any flops. It must synchronize that level itself unless it uses it as a clock.

Top module: `gpio_override_port`

## Requirements
- R1: After reset the direction, output and pull-up-disable registers read 0, every pin's driver is off and, with no takeover active, every pull-up is off.
- R2: A write with reg_addr 0 loads the direction register, reg_addr 1 loads the output register, and reg_addr 3 loads bit 0 into the pull-up-disable bit. Reads at the same addresses return those values combinationally, with the upper bits of address 3 reading 0.
- R3: Without a pull-up takeover, a pin's pull-up is on exactly when its direction bit is 0, its output bit is 1 and pull-up-disable is 0.
- R4: With a pull-up takeover enabled, the pin's pull-up equals the takeover value, regardless of the direction, output and disable bits.
- R5: With a driver takeover enabled, the pin's output enable equals the takeover value. Otherwise it equals the pin's direction bit.
- R6: When a pin's output enable is 1 and its level takeover is enabled, the driven level is the takeover value. In every other case it is the pin's output register bit.
- R7: Each clock edge on which a pin's toggle request is 1 inverts that pin's stored output bit. A write to address 1 on the same edge overrides the toggle, so the written value is stored.
- R8: With an input-enable takeover, the pin's input enable equals the takeover value. Otherwise the input is enabled when sleep_active is 0 and disabled when it is 1.
- R9: alt_din equals pad_in ANDed with the pin's input enable, combinationally and with no register on the path. A disabled input yields 0.
- R10: A read at reg_addr 2 returns the gated pin levels after two clock edges of synchronization. Writes to address 2 change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address: 0 direction, 1 output, 2 pin readback, 3 control |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr |
| sleep_active | input | 1 | System is in a sleep state |
| pu_ovr_en | input | 8 | Per-pin pull-up takeover enable |
| pu_ovr_val | input | 8 | Per-pin pull-up takeover value |
| oe_ovr_en | input | 8 | Per-pin driver-enable takeover enable |
| oe_ovr_val | input | 8 | Per-pin driver-enable takeover value |
| dv_ovr_en | input | 8 | Per-pin driven-level takeover enable |
| dv_ovr_val | input | 8 | Per-pin driven-level takeover value |
| tgl_req | input | 8 | Per-pin request to invert the stored output bit |
| ie_ovr_en | input | 8 | Per-pin input-enable takeover enable |
| ie_ovr_val | input | 8 | Per-pin input-enable takeover value |
| pad_in | input | 8 | Sampled pad levels |
| pull_en | output | 8 | Per-pin pull-up enable |
| drv_en | output | 8 | Per-pin output driver enable |
| drv_val | output | 8 | Per-pin driven level |
| alt_din | output | 8 | Gated, unsynchronized input to the peripheral |

## Verification
The bench builds the port with its defaults: eight pins and a two-stage synchronizer. With eight pins, random 8-bit vectors mix takeover and non-takeover pins in a single cycle, so each pin's mux is checked against its neighbours in different states. With two synchronizer stages, the readback latency is short enough to check on every random iteration. Directed cases cover odd and even toggle counts, a write and a toggle on the same edge, writes to the read-only address, and sleep with and without an input takeover.

// File: rtl/gpio_ovr_pkg.sv
// Package: shared address map and widths for the takeover-capable I/O port.
// Assumes a two-bit register address space.
package gpio_ovr_pkg;
    localparam int REG_ADDR_W = 2;

    typedef enum logic [REG_ADDR_W-1:0] {
        ADDR_DIR  = 2'd0,
        ADDR_PORT = 2'd1,
        ADDR_PIN  = 2'd2,
        ADDR_CTRL = 2'd3
    } gpio_addr_e;

    // Bit position of the pull-up disable flag inside the control register.
    localparam int CTRL_PUD_BIT = 0;
endpackage

// File: rtl/gpio_regfile.sv
// Module: software-visible state of the port (direction, output, pull-up disable).
// Applies per-pin toggle requests to the output register; a write to the
// output register on the same edge wins. Assumes synchronous active-low reset.
module gpio_regfile
    import gpio_ovr_pkg::*;
#(
    parameter int PIN_COUNT = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [REG_ADDR_W-1:0] addr,
    input  logic [PIN_COUNT-1:0]  wdata,
    input  logic [PIN_COUNT-1:0]  tgl,
    output logic [PIN_COUNT-1:0]  dir_q,
    output logic [PIN_COUNT-1:0]  port_q,
    output logic                  pud_q
);
    logic wr_dir, wr_port, wr_ctrl;

    // Decode which register the current write targets.
    always_comb begin
        wr_dir  = wr_en && (gpio_addr_e'(addr) == ADDR_DIR);
        wr_port = wr_en && (gpio_addr_e'(addr) == ADDR_PORT);
        wr_ctrl = wr_en && (gpio_addr_e'(addr) == ADDR_CTRL);
    end

    // Direction register.
    always_ff @(posedge clk) begin
        if (!rst_n)      dir_q <= '0;
        else if (wr_dir) dir_q <= wdata;
    end

    // Output register: write has priority, else toggle requests invert bits.
    always_ff @(posedge clk) begin
        if (!rst_n)       port_q <= '0;
        else if (wr_port) port_q <= wdata;
        else              port_q <= port_q ^ tgl;
    end

    // Port-wide pull-up disable flag.
    always_ff @(posedge clk) begin
        if (!rst_n)       pud_q <= 1'b0;
        else if (wr_ctrl) pud_q <= wdata[CTRL_PUD_BIT];
    end

    assert_write_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_port |=> (port_q == $past(wdata)));

    assert_toggle_flip_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_port |=> (port_q == ($past(port_q) ^ $past(tgl))));

    assert_pin_addr_inert_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && gpio_addr_e'(addr) == ADDR_PIN) |=>
            (dir_q == $past(dir_q)) && (pud_q == $past(pud_q)));
endmodule

// File: rtl/gpio_pin_ctrl.sv
// Module: per-pin combinational arbitration between software settings and
// peripheral takeover controls. Produces pull-up, driver enable, driven level
// and input enable. Assumes all inputs are stable between clock edges.
module gpio_pin_ctrl (
    input  logic dir_bit,
    input  logic port_bit,
    input  logic pud,
    input  logic sleep_active,
    input  logic pu_en,
    input  logic pu_val,
    input  logic oe_en,
    input  logic oe_val,
    input  logic dv_en,
    input  logic dv_val,
    input  logic ie_en,
    input  logic ie_val,
    output logic pull_en,
    output logic drv_en,
    output logic drv_val,
    output logic din_en
);
    logic sw_pull;

    // Pull-up: takeover value, or the input-high-without-disable pattern.
    always_comb begin
        sw_pull = !dir_bit && port_bit && !pud;
        pull_en = pu_en ? pu_val : sw_pull;
    end

    // Driver enable and driven level.
    always_comb begin
        drv_en  = oe_en ? oe_val : dir_bit;
        drv_val = (drv_en && dv_en) ? dv_val : port_bit;
    end

    // Input enable: takeover, else awake-state gating.
    always_comb begin
        din_en = ie_en ? ie_val : !sleep_active;
    end
endmodule

// File: rtl/gpio_input_sync.sv
// Module: gates pad levels by input enable, exposes the gated value unregistered,
// and passes it through a SYNC_STAGES-deep flop chain for readback.
// Assumes SYNC_STAGES >= 2 and pad_in asynchronous to clk.
module gpio_input_sync #(
    parameter int PIN_COUNT   = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [PIN_COUNT-1:0] pad_in,
    input  logic [PIN_COUNT-1:0] din_en,
    output logic [PIN_COUNT-1:0] gated,
    output logic [PIN_COUNT-1:0] pin_sync
);
    logic [PIN_COUNT-1:0] stage_q [SYNC_STAGES];

    // Force disabled inputs to zero before anything consumes them.
    always_comb gated = pad_in & din_en;

    // Synchronizer chain, first stage captures the gated level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SYNC_STAGES; s++) stage_q[s] <= '0;
        end else begin
            stage_q[0] <= gated;
            for (int s = 1; s < SYNC_STAGES; s++) stage_q[s] <= stage_q[s-1];
        end
    end

    // Last stage is the readback value.
    always_comb pin_sync = stage_q[SYNC_STAGES-1];

    assert_gate_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ((pad_in & ~din_en) != '0) |-> ((gated & ~din_en) == '0));

    assert_first_stage_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (stage_q[0] == $past(gated)));

    assert_last_stage_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (pin_sync == $past(stage_q[SYNC_STAGES-2])));
endmodule

// File: rtl/gpio_override_port.sv
// Module: top of the takeover-capable I/O port. Holds the register file,
// one arbitration slice per pin and the input synchronizer, and muxes reads.
// Assumes synchronous active-low reset and a single clock domain for registers.
module gpio_override_port
    import gpio_ovr_pkg::*;
#(
    parameter int PIN_COUNT   = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  reg_wr,
    input  logic [REG_ADDR_W-1:0] reg_addr,
    input  logic [PIN_COUNT-1:0]  reg_wdata,
    output logic [PIN_COUNT-1:0]  reg_rdata,
    input  logic                  sleep_active,
    input  logic [PIN_COUNT-1:0]  pu_ovr_en,
    input  logic [PIN_COUNT-1:0]  pu_ovr_val,
    input  logic [PIN_COUNT-1:0]  oe_ovr_en,
    input  logic [PIN_COUNT-1:0]  oe_ovr_val,
    input  logic [PIN_COUNT-1:0]  dv_ovr_en,
    input  logic [PIN_COUNT-1:0]  dv_ovr_val,
    input  logic [PIN_COUNT-1:0]  tgl_req,
    input  logic [PIN_COUNT-1:0]  ie_ovr_en,
    input  logic [PIN_COUNT-1:0]  ie_ovr_val,
    input  logic [PIN_COUNT-1:0]  pad_in,
    output logic [PIN_COUNT-1:0]  pull_en,
    output logic [PIN_COUNT-1:0]  drv_en,
    output logic [PIN_COUNT-1:0]  drv_val,
    output logic [PIN_COUNT-1:0]  alt_din
);
    localparam int CTRL_PAD_W = PIN_COUNT - 1;

    logic [PIN_COUNT-1:0] dir_q, port_q, din_en, pin_sync;
    logic                 pud_q;

    gpio_regfile #(.PIN_COUNT(PIN_COUNT)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (reg_wr),
        .addr   (reg_addr),
        .wdata  (reg_wdata),
        .tgl    (tgl_req),
        .dir_q  (dir_q),
        .port_q (port_q),
        .pud_q  (pud_q)
    );

    for (genvar p = 0; p < PIN_COUNT; p++) begin : g_pin
        gpio_pin_ctrl u_ctrl (
            .dir_bit      (dir_q[p]),
            .port_bit     (port_q[p]),
            .pud          (pud_q),
            .sleep_active (sleep_active),
            .pu_en        (pu_ovr_en[p]),
            .pu_val       (pu_ovr_val[p]),
            .oe_en        (oe_ovr_en[p]),
            .oe_val       (oe_ovr_val[p]),
            .dv_en        (dv_ovr_en[p]),
            .dv_val       (dv_ovr_val[p]),
            .ie_en        (ie_ovr_en[p]),
            .ie_val       (ie_ovr_val[p]),
            .pull_en      (pull_en[p]),
            .drv_en       (drv_en[p]),
            .drv_val      (drv_val[p]),
            .din_en       (din_en[p])
        );

        assert_pull_default_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (!pu_ovr_en[p] && dir_q[p]) |-> !pull_en[p]);

        assert_pull_takeover_R4: assert property (@(posedge clk) disable iff (!rst_n)
            pu_ovr_en[p] |-> (pull_en[p] == pu_ovr_val[p]));

        assert_oe_select_R5: assert property (@(posedge clk) disable iff (!rst_n)
            !oe_ovr_en[p] |-> (drv_en[p] == dir_q[p]));

        assert_level_default_R6: assert property (@(posedge clk) disable iff (!rst_n)
            !dv_ovr_en[p] |-> (drv_val[p] == port_q[p]));

        assert_sleep_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (!ie_ovr_en[p] && sleep_active) |-> !alt_din[p]);
    end

    gpio_input_sync #(
        .PIN_COUNT   (PIN_COUNT),
        .SYNC_STAGES (SYNC_STAGES)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .pad_in   (pad_in),
        .din_en   (din_en),
        .gated    (alt_din),
        .pin_sync (pin_sync)
    );

    // Combinational register read mux.
    always_comb begin
        unique case (gpio_addr_e'(reg_addr))
            ADDR_DIR:  reg_rdata = dir_q;
            ADDR_PORT: reg_rdata = port_q;
            ADDR_PIN:  reg_rdata = pin_sync;
            ADDR_CTRL: reg_rdata = {{CTRL_PAD_W{1'b0}}, pud_q};
            default:   reg_rdata = '0;
        endcase
    end

    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (dir_q == '0) && (port_q == '0) && !pud_q);

    assert_ctrl_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && gpio_addr_e'(reg_addr) == ADDR_CTRL) |=> (pud_q == $past(reg_wdata[0])));
endmodule

// File: tb/tb_gpio_override_port.sv
`timescale 1ns/1ps
module tb_gpio_override_port;
    localparam int N = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         reg_wr = 1'b0;
    logic [1:0]   reg_addr = '0;
    logic [N-1:0] reg_wdata = '0;
    logic [N-1:0] reg_rdata;
    logic         sleep_active = 1'b0;
    logic [N-1:0] pu_ovr_en = '0, pu_ovr_val = '0, oe_ovr_en = '0, oe_ovr_val = '0;
    logic [N-1:0] dv_ovr_en = '0, dv_ovr_val = '0, tgl_req = '0;
    logic [N-1:0] ie_ovr_en = '0, ie_ovr_val = '0, pad_in = '0;
    logic [N-1:0] pull_en, drv_en, drv_val, alt_din;

    int checks = 0;
    int failures = 0;
    logic [N-1:0] sh_dir = '0, sh_port = '0;
    logic         sh_pud = 1'b0;

    always #2 clk = ~clk;

    gpio_override_port #(.PIN_COUNT(N), .SYNC_STAGES(2)) dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sleep_active(sleep_active),
        .pu_ovr_en(pu_ovr_en), .pu_ovr_val(pu_ovr_val), .oe_ovr_en(oe_ovr_en),
        .oe_ovr_val(oe_ovr_val), .dv_ovr_en(dv_ovr_en), .dv_ovr_val(dv_ovr_val),
        .tgl_req(tgl_req), .ie_ovr_en(ie_ovr_en), .ie_ovr_val(ie_ovr_val),
        .pad_in(pad_in), .pull_en(pull_en), .drv_en(drv_en), .drv_val(drv_val),
        .alt_din(alt_din)
    );

    function automatic logic [N-1:0] f_pull();
        return (pu_ovr_en & pu_ovr_val) | (~pu_ovr_en & ~sh_dir & sh_port & {N{~sh_pud}});
    endfunction
    function automatic logic [N-1:0] f_oe();
        return (oe_ovr_en & oe_ovr_val) | (~oe_ovr_en & sh_dir);
    endfunction
    function automatic logic [N-1:0] f_lvl();
        logic [N-1:0] take = f_oe() & dv_ovr_en;
        return (take & dv_ovr_val) | (~take & sh_port);
    endfunction
    function automatic logic [N-1:0] f_ie();
        return (ie_ovr_en & ie_ovr_val) | (~ie_ovr_en & {N{~sleep_active}});
    endfunction

    task automatic chk(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [N-1:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, input string tag, input logic [N-1:0] exp);
        reg_addr = a;
        #0.5;
        chk(tag, reg_rdata, exp);
    endtask

    task automatic check_outputs(input string ctx);
        #0.5;
        chk({ctx, " R3/R4 pull_en"}, pull_en, f_pull());
        chk({ctx, " R5 drv_en"}, drv_en, f_oe());
        chk({ctx, " R6 drv_val"}, drv_val, f_lvl());
        chk({ctx, " R8/R9 alt_din"}, alt_din, pad_in & f_ie());
    endtask

    initial begin
        #400000;
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        rd(2'd0, "R1 dir after reset", '0);
        rd(2'd1, "R1 port after reset", '0);
        rd(2'd3, "R1 ctrl after reset", '0);
        chk("R1 drv_en after reset", drv_en, '0);
        chk("R1 pull_en after reset", pull_en, '0);

        // R2: register writes and reads
        wr(2'd0, 8'hA5); sh_dir = 8'hA5;
        wr(2'd1, 8'h3C); sh_port = 8'h3C;
        wr(2'd3, 8'hFF); sh_pud = 1'b1;
        rd(2'd0, "R2 dir readback", 8'hA5);
        rd(2'd1, "R2 port readback", 8'h3C);
        rd(2'd3, "R2 ctrl readback", 8'h01);
        check_outputs("pud set");
        wr(2'd3, 8'h00); sh_pud = 1'b0;
        check_outputs("pud clear");

        // R10: write to readback address is ignored; readback after two edges
        pad_in = 8'h5A;
        wr(2'd2, 8'hFF);
        rd(2'd0, "R10 dir unchanged by addr2 write", 8'hA5);
        rd(2'd1, "R10 port unchanged by addr2 write", 8'h3C);
        rd(2'd3, "R10 ctrl unchanged by addr2 write", 8'h00);
        @(negedge clk); @(negedge clk);
        rd(2'd2, "R10 pin readback", 8'h5A);

        // R7: odd toggle count
        wr(2'd1, 8'h0F); sh_port = 8'h0F;
        tgl_req = 8'h81;
        repeat (3) @(negedge clk);
        tgl_req = 8'h00;
        rd(2'd1, "R7 three toggles", 8'h8E);
        // R7: even toggle count
        tgl_req = 8'h18;
        repeat (2) @(negedge clk);
        tgl_req = 8'h00;
        rd(2'd1, "R7 two toggles", 8'h8E);
        // R7: write wins over toggle on the same edge
        tgl_req = 8'hFF;
        reg_wr = 1'b1; reg_addr = 2'd1; reg_wdata = 8'h55;
        @(negedge clk);
        reg_wr = 1'b0; tgl_req = 8'h00;
        rd(2'd1, "R7 write beats toggle", 8'h55);
        sh_port = 8'h55;

        // R8: sleep with and without input takeover
        pad_in = 8'hFF; sleep_active = 1'b1;
        ie_ovr_en = 8'hF0; ie_ovr_val = 8'h30;
        #0.5;
        chk("R8 sleep gating alt_din", alt_din, 8'h30);
        @(negedge clk); @(negedge clk);
        rd(2'd2, "R8 sleep gating readback", 8'h30);
        sleep_active = 1'b0;
        #0.5;
        chk("R8 awake gating alt_din", alt_din, 8'h3F);
        ie_ovr_en = '0; ie_ovr_val = '0;

        // Random mix of settings and takeovers
        for (int it = 0; it < 300; it++) begin
            logic [N-1:0] d = N'($urandom);
            logic [N-1:0] p = N'($urandom);
            logic         u = 1'($urandom);
            wr(2'd0, d); sh_dir = d;
            wr(2'd1, p); sh_port = p;
            wr(2'd3, {7'd0, u}); sh_pud = u;
            pu_ovr_en = N'($urandom); pu_ovr_val = N'($urandom);
            oe_ovr_en = N'($urandom); oe_ovr_val = N'($urandom);
            dv_ovr_en = N'($urandom); dv_ovr_val = N'($urandom);
            ie_ovr_en = N'($urandom); ie_ovr_val = N'($urandom);
            sleep_active = 1'($urandom);
            pad_in = N'($urandom);
            check_outputs("random");
            @(negedge clk); @(negedge clk);
            rd(2'd2, "R10 random readback", pad_in & f_ie());
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule